// File: doc/BRIEF.md
# Machine Cycle Timing and Code Fetch Sequencer

This block paces an 8-bit controller core from its oscillator clock. Each machine cycle is twelve oscillator periods long. The cycle is split into six states, and each state has two phases. From that timing grid the block produces the address latch enable and the code fetch strobe. It also produces a pulse that loads the opcode into the instruction register, a pulse that advances the program counter, and a pulse that marks the last period of each instruction.

The decoder gives the sequencer three attributes of the current instruction: its length in bytes, its length in machine cycles (one, two or four), and whether it moves data to or from external memory. The sequencer samples these once, in the period where the opcode is latched. From them it decides which code fetches advance the program counter and which are dummy reads. It also decides when the instruction ends, and whether the second machine cycle of an external data move gives up its code fetches so the bus can carry the data transfer.

Top module: `mcFetchSeq`

## Requirements
- R1: Periods run in a fixed loop of twelve. `stateNum` counts 1 to 6 and `phaseTwo` is 0 in the first period of a state and 1 in the second. Each state covers two periods.
- R2: `ale` is high for the two periods from state 1 phase 2 through state 2 phase 1. In every machine cycle except a suppressed one (R10), it is also high from state 4 phase 2 through state 5 phase 1.
- R3: `codeFetch` is high during all of state 1 and all of state 4 in every machine cycle, except a suppressed one (R10).
- R4: In the first machine cycle of an instruction, `opLatch` pulses for exactly one period, at state 1 phase 2. `pcInc` pulses in the same period for the opcode byte.
- R5: `byteCount` and `cycleCode` are sampled only at the opcode period and held until the instruction ends. Byte count values 1, 2 and 3 are the instruction length, and 0 counts as 1. `cycleCode` 2'b00 means one cycle, 2'b01 means two cycles, and 2'b10 or 2'b11 means four cycles. Changes to these inputs later in the instruction have no effect.
- R6: For an instruction of two or more bytes, `pcInc` pulses at state 4 phase 2 of the first machine cycle.
- R7: For a one-byte instruction, the state 4 fetch of the first cycle still raises `codeFetch`, but `pcInc` stays low.
- R8: For a three-byte instruction of at least two cycles, `pcInc` pulses at state 1 phase 2 of the second machine cycle.
- R9: `instrDone` pulses at state 6 phase 2 of the last machine cycle of an instruction. The next period is state 1 phase 1 of the first cycle of the next instruction.
- R10: When `extData` was sampled high, the second machine cycle has no `codeFetch` and no second `ale` pulse. The first `ale` pulse of that cycle is kept.
- R11: While `rstN` is low, `ale`, `codeFetch`, `opLatch`, `pcInc` and `instrDone` are low at once. The timing shows state 1 phase 1, and after release the first instruction starts at state 1 phase 1.
- R12: Code fetches in machine cycles after the first raise `codeFetch` but never `pcInc`, except the third-byte fetch of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per phase |
| rstN | input | 1 | Asynchronous reset, active low |
| byteCount | input | 2 | Instruction length in bytes (0 counts as 1) |
| cycleCode | input | 2 | Instruction length in cycles: 00 one, 01 two, 1x four |
| extData | input | 1 | Instruction is an external data move |
| stateNum | output | 3 | Current state, 1 to 6 |
| phaseTwo | output | 1 | High in the second phase of a state |
| ale | output | 1 | Address latch enable |
| codeFetch | output | 1 | Code memory read strobe |
| opLatch | output | 1 | Opcode load pulse |
| pcInc | output | 1 | Program counter advance pulse |
| instrDone | output | 1 | Last period of the instruction |

## Verification
The bench checks every period of one-, two- and three-byte instructions and of one-, two- and four-cycle instructions against a timing grid it derives from the requirements. If the dummy fetch handling were wrong, a one-byte instruction would advance the program counter at state 4, or a later cycle would skip its fetch. An external data move must lose only the second cycle's fetches and its second latch pulse; a design that latched attributes too late, or suppressed the wrong cycle, would change the strobes around that cycle. The decoder inputs are scrambled right after the opcode period, so any design that reads them live changes its cycle count or its increments. Reset is also asserted in the middle of a four-cycle instruction, to show that the strobes drop at once and that the sequencer restarts at the first period.

// File: rtl/mcTimingPkg.sv
package mcTimingPkg;

  // grid of one machine cycle
  localparam int PHASES     = 2;
  localparam int STATES     = 6;
  localparam int SLOTS      = PHASES * STATES;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int MAX_CYCLES = 4;
  localparam int CYC_IDX_W  = $clog2(MAX_CYCLES);

  // slot index = (state - 1) * PHASES + (phase - 1)
  localparam logic [SLOT_W-1:0] SLOT_OPCODE  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_ALE_A0  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_ALE_A1  = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] SLOT_ALE_B0  = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] SLOT_ALE_B1  = SLOT_W'(8);
  localparam logic [SLOT_W-1:0] SLOT_SECBYTE = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] SLOT_LAST    = SLOT_W'(SLOTS - 1);
  localparam int               FETCH_STATE_A = 1;
  localparam int               FETCH_STATE_B = 4;

  // control -> decode
  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              cycleEnd;
    logic              opSlot;
  } slotStrobes_t;

  // per-instruction cycle context
  typedef struct packed {
    logic firstCyc;
    logic lastCyc;
    logic skipCyc;
    logic multiByte;
    logic thirdByteCyc;
    logic laterCyc;
  } cycInfo_t;

endpackage

// File: rtl/mcSlotGen.sv
module mcSlotGen
  import mcTimingPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output slotStrobes_t strb
);

  logic [SLOT_W-1:0] slotQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      slotQ <= '0;
    else if (slotQ == SLOT_LAST)
      slotQ <= '0;
    else
      slotQ <= slotQ + 1'b1;
  end

  always_comb begin
    strb.slot     = slotQ;
    strb.cycleEnd = (slotQ == SLOT_LAST);
    strb.opSlot   = (slotQ == SLOT_OPCODE);
  end

endmodule

// File: rtl/mcCycleTrack.sv
module mcCycleTrack
  import mcTimingPkg::*;
#(
  parameter int BYTE_W = 2,
  parameter int CYC_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobes_t      strb,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic [CYC_W-1:0]  cycleCode,
  input  logic              extData,
  output cycInfo_t          info
);

  localparam logic [BYTE_W-1:0] ONE_BYTE   = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] TWO_BYTES  = BYTE_W'(2);
  localparam logic [BYTE_W-1:0] THREE_BYTE = BYTE_W'(3);

  logic [CYC_IDX_W-1:0] cycQ;
  logic [CYC_IDX_W-1:0] lastIdxQ;
  logic [BYTE_W-1:0]    bytesQ;
  logic                 extQ;
  logic                 loadAttr;
  logic [CYC_IDX_W-1:0] lastIdxIn;

  // cycle code -> index of final machine cycle
  always_comb begin
    case (cycleCode)
      CYC_W'(0): lastIdxIn = CYC_IDX_W'(0);
      CYC_W'(1): lastIdxIn = CYC_IDX_W'(1);
      default:   lastIdxIn = CYC_IDX_W'(MAX_CYCLES - 1);
    endcase
  end

  assign loadAttr = strb.opSlot && (cycQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIdxQ <= '0;
      bytesQ   <= ONE_BYTE;
      extQ     <= 1'b0;
    end else if (loadAttr) begin
      lastIdxQ <= lastIdxIn;
      bytesQ   <= (byteCount == '0) ? ONE_BYTE : byteCount;
      extQ     <= extData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cycQ <= '0;
    else if (strb.cycleEnd)
      cycQ <= (cycQ == lastIdxQ) ? '0 : cycQ + 1'b1;
  end

  always_comb begin
    info.firstCyc     = (cycQ == '0);
    info.lastCyc      = (cycQ == lastIdxQ);
    info.skipCyc      = extQ && (cycQ == CYC_IDX_W'(1));
    info.multiByte    = (bytesQ >= TWO_BYTES);
    info.thirdByteCyc = (cycQ == CYC_IDX_W'(1)) && (bytesQ == THREE_BYTE);
    info.laterCyc     = (cycQ != '0);
  end

endmodule

// File: rtl/mcStrobeDecode.sv
module mcStrobeDecode
  import mcTimingPkg::*;
(
  input  logic         rstN,
  input  slotStrobes_t strb,
  input  cycInfo_t     info,
  output logic [2:0]   stateNum,
  output logic         phaseTwo,
  output logic         ale,
  output logic         codeFetch,
  output logic         opLatch,
  output logic         pcInc,
  output logic         instrDone
);

  logic [2:0] stateCur;
  logic       aleA;
  logic       aleB;
  logic       fetchSlot;
  logic       incOpc;
  logic       incSecond;
  logic       incThird;

  always_comb begin
    stateCur  = 3'(strb.slot[SLOT_W-1:1]) + 3'd1;
    aleA      = (strb.slot == SLOT_ALE_A0) || (strb.slot == SLOT_ALE_A1);
    aleB      = (strb.slot == SLOT_ALE_B0) || (strb.slot == SLOT_ALE_B1);
    fetchSlot = (stateCur == 3'(FETCH_STATE_A)) || (stateCur == 3'(FETCH_STATE_B));
    incOpc    = strb.opSlot && info.firstCyc;
    incSecond = (strb.slot == SLOT_SECBYTE) && info.firstCyc && info.multiByte;
    incThird  = strb.opSlot && info.thirdByteCyc && !info.skipCyc;
  end

  always_comb begin
    stateNum  = stateCur;
    phaseTwo  = strb.slot[0];
    ale       = rstN && (aleA || (aleB && !info.skipCyc));
    codeFetch = rstN && fetchSlot && !info.skipCyc;
    opLatch   = rstN && incOpc;
    pcInc     = rstN && (incOpc || incSecond || incThird);
    instrDone = rstN && strb.cycleEnd && info.lastCyc;
  end

endmodule

// File: rtl/mcFetchSeq.sv
module mcFetchSeq
  import mcTimingPkg::*;
#(
  parameter int BYTE_W = 2,
  parameter int CYC_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteCount,
  input  logic [CYC_W-1:0]  cycleCode,
  input  logic              extData,
  output logic [2:0]        stateNum,
  output logic              phaseTwo,
  output logic              ale,
  output logic              codeFetch,
  output logic              opLatch,
  output logic              pcInc,
  output logic              instrDone
);

  slotStrobes_t strb;
  cycInfo_t     info;

  mcSlotGen slotGen (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  mcCycleTrack #(
    .BYTE_W (BYTE_W),
    .CYC_W  (CYC_W)
  ) cycTrack (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteCount (byteCount),
    .cycleCode (cycleCode),
    .extData   (extData),
    .info      (info)
  );

  mcStrobeDecode strobeDec (
    .rstN      (rstN),
    .strb      (strb),
    .info      (info),
    .stateNum  (stateNum),
    .phaseTwo  (phaseTwo),
    .ale       (ale),
    .codeFetch (codeFetch),
    .opLatch   (opLatch),
    .pcInc     (pcInc),
    .instrDone (instrDone)
  );

endmodule

// File: rtl/mcFetchSeqChk.sv
module mcFetchSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] stateNum,
  input logic       phaseTwo,
  input logic       ale,
  input logic       codeFetch,
  input logic       opLatch,
  input logic       pcInc,
  input logic       instrDone
);

  // R1
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (phaseTwo != $past(phaseTwo)));

  // R2
  ale_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |-> phaseTwo);

  // R4
  op_latch_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    opLatch |-> (stateNum == 3'd1 && phaseTwo && ale && codeFetch && pcInc));

  // R12
  inc_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcInc |-> codeFetch);

  // R9
  done_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |=> (stateNum == 3'd1 && !phaseTwo));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!ale && !codeFetch && !opLatch && !pcInc && !instrDone));

endmodule

bind mcFetchSeq mcFetchSeqChk seqChk (.*);

// File: tb/mcFetchSeq_test.sv
module mcFetchSeq_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] byteCount;
  logic [1:0] cycleCode;
  logic       extData;
  logic [2:0] stateNum;
  logic       phaseTwo;
  logic       ale;
  logic       codeFetch;
  logic       opLatch;
  logic       pcInc;
  logic       instrDone;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mcFetchSeq uut (
    .clk       (clk),
    .rstN      (rstN),
    .byteCount (byteCount),
    .cycleCode (cycleCode),
    .extData   (extData),
    .stateNum  (stateNum),
    .phaseTwo  (phaseTwo),
    .ale       (ale),
    .codeFetch (codeFetch),
    .opLatch   (opLatch),
    .pcInc     (pcInc),
    .instrDone (instrDone)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  task automatic checkQuiet(input string req);
    check(req, "stateNum in reset", int'(stateNum), 1);
    check(req, "phaseTwo in reset", int'(phaseTwo), 0);
    check(req, "ale in reset", int'(ale), 0);
    check(req, "codeFetch in reset", int'(codeFetch), 0);
    check(req, "opLatch in reset", int'(opLatch), 0);
    check(req, "pcInc in reset", int'(pcInc), 0);
    check(req, "instrDone in reset", int'(instrDone), 0);
  endtask

  // One instruction, entered at state 1 phase 1 just after a falling edge.
  // stopCyc/stopSlot >= 0 returns early, just before that period is checked.
  task automatic runInstr(input int bytesIn, input int codeIn, input bit extIn,
                          input string scen, input int stopCyc, input int stopSlot);
    int nb;
    int ncyc;
    nb   = (bytesIn == 0) ? 1 : bytesIn;
    ncyc = (codeIn == 0) ? 1 : (codeIn == 1) ? 2 : 4;
    for (int c = 0; c < ncyc; c++) begin
      for (int s = 0; s < 12; s++) begin
        bit skip;
        bit expAle;
        bit expFetch;
        bit expInc;
        string aleReq;
        string fetchReq;
        string incReq;
        if (c == stopCyc && s == stopSlot) return;
        if (c == 0 && s == 0) begin
          byteCount = 2'(bytesIn);
          cycleCode = 2'(codeIn);
          extData   = extIn;
        end
        if (c == 0 && s == 2) begin
          // R5: scramble after the sampling period
          byteCount = ~2'(bytesIn);
          cycleCode = ~2'(codeIn);
          extData   = ~extIn;
        end
        #1;
        skip     = extIn && (c == 1);
        expAle   = (s == 1 || s == 2) || ((s == 7 || s == 8) && !skip);
        expFetch = (s == 0 || s == 1 || s == 6 || s == 7) && !skip;
        expInc   = (c == 0 && s == 1) || (c == 0 && s == 7 && nb >= 2) ||
                   (c == 1 && s == 1 && nb == 3 && !skip);
        aleReq   = skip ? "R10" : "R2";
        fetchReq = skip ? "R10" : (c > 0) ? "R12" : (s >= 6 && nb < 2) ? "R7" : "R3";
        incReq   = (c == 0 && s == 7) ? ((nb >= 2) ? "R6" : "R7") :
                   (c == 1 && s == 1) ? ((nb == 3) ? "R8" : "R12") :
                   (c > 0) ? "R12" : "R4";
        check({"R1 ", scen}, "stateNum", int'(stateNum), s / 2 + 1);
        check({"R1 ", scen}, "phaseTwo", int'(phaseTwo), s % 2);
        check({aleReq, " ", scen}, "ale", int'(ale), int'(expAle));
        check({fetchReq, " ", scen}, "codeFetch", int'(codeFetch), int'(expFetch));
        check({"R4 ", scen}, "opLatch", int'(opLatch), int'(c == 0 && s == 1));
        check({incReq, " ", scen}, "pcInc", int'(pcInc), int'(expInc));
        check({"R9 ", scen}, "instrDone", int'(instrDone), int'(s == 11 && c == ncyc - 1));
        @(negedge clk);
      end
    end
  endtask

  task automatic testReset();
    // R11: quiet while held
    rstN      = 1'b0;
    byteCount = 2'd1;
    cycleCode = 2'd0;
    extData   = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1;
      checkQuiet("R11");
    end
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testShortInstr();
    // R7 R4 R9: one byte, one cycle, twice in a row
    runInstr(1, 0, 1'b0, "1B1C", -1, -1);
    runInstr(1, 0, 1'b0, "1B1C again", -1, -1);
  endtask

  task automatic testTwoByte();
    // R6
    runInstr(2, 0, 1'b0, "2B1C", -1, -1);
    runInstr(2, 1, 1'b0, "2B2C", -1, -1);
  endtask

  task automatic testThreeByte();
    // R8
    runInstr(3, 1, 1'b0, "3B2C", -1, -1);
  endtask

  task automatic testFourCycle();
    // R12 R9 R5: code 2'b10 and 2'b11 both mean four cycles
    runInstr(1, 2, 1'b0, "1B4C", -1, -1);
    runInstr(2, 3, 1'b0, "2B4C code3", -1, -1);
  endtask

  task automatic testExtMove();
    // R10: second cycle gives up fetches and the late latch pulse
    runInstr(1, 1, 1'b1, "ext move", -1, -1);
    // R10: extData ignored for a one-cycle instruction
    runInstr(1, 0, 1'b1, "ext 1C", -1, -1);
    runInstr(1, 1, 1'b0, "after ext", -1, -1);
  endtask

  task automatic testZeroBytes();
    // R5: byte count 0 counts as one byte
    runInstr(0, 1, 1'b0, "R5 zero bytes", -1, -1);
  endtask

  task automatic testMidReset();
    // R11: reset in the second cycle of a four-cycle instruction
    runInstr(2, 2, 1'b0, "pre reset", 1, 5);
    rstN = 1'b0;
    #1;
    checkQuiet("R11 async");
    repeat (2) begin
      @(negedge clk);
      #1;
      checkQuiet("R11 held");
    end
    @(negedge clk);
    rstN = 1'b1;
    runInstr(3, 1, 1'b0, "R11 restart", -1, -1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testShortInstr();
    testTwoByte();
    testThreeByte();
    testFourCycle();
    testExtMove();
    testZeroBytes();
    testMidReset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule